// File: doc/BRIEF.md
# Legacy Memory Attribute and SMRAM Decoder

This block sits beside the host bridge's address path. It looks at a 20-bit legacy address and a read/write indication, and decides how the access is routed. The access can go to system DRAM or be forwarded to PCI. A write can also be refused because the target area is shadowed read-only. The decision covers the 64 KB top boot area, the twelve 16 KB expansion ROM segments below it, and the 128 KB SMRAM window at 0xA0000. Any address below 0xA0000 is left alone for a default decoder.

Routing is set by seven attribute bytes and one SMRAM control byte. All eight are reached through a byte-addressed configuration port with dword data and byte enables. A separate input tells the block when the processor is in system management mode. The decode is purely combinational from the address, that input and the registered configuration state. A configuration write therefore changes routing from the clock edge on which it is accepted.

The configuration port uses valid/ready. `cfg_ready` is held high, so the port never applies back-pressure. A write is taken on every rising clock edge on which `cfg_valid` and `cfg_we` are both high. Read data is combinational on `cfg_addr` and needs no handshake.

Top module: `legacy_map_decoder`

## Requirements
- R1: After reset, bytes 0x59 to 0x5F read 0x00 and byte 0x72 reads 0x02. Every shadow area then forwards both reads and writes to PCI.
- R2: Addresses 0xF0000 to 0xFFFFF take their 2-bit attribute from bits 5:4 of byte 0x59.
- R3: Segment k (0 to 11) covers 0xC0000 + k*0x4000 and is 16 KB long. It takes its attribute from byte 0x5A + k/2: bits 1:0 when k is even, bits 5:4 when k is odd.
- R4: Attribute 3 routes both reads and writes to DRAM (`dram_sel`=1).
- R5: Attribute 1 routes reads to DRAM. A write raises `wr_blocked` alone, with neither select asserted, and `wr_blocked` is never high on a read.
- R6: Attributes 0 and 2 route both reads and writes to PCI (`pci_sel`=1).
- R7: Addresses 0xA0000 to 0xBFFFF go to DRAM when (`smm_active` and bit 3 of byte 0x72) or bit 6 of byte 0x72; otherwise they go to PCI. This window never raises `wr_blocked`, and a change of `smm_active` changes the routing in the same cycle.
- R8: Addresses below 0xA0000 assert none of `dram_sel`, `pci_sel` and `wr_blocked`.
- R9: A write at dword address `cfg_addr[7:2]` updates byte (`cfg_addr[7:2]`*4 + n) from `cfg_wdata[8n+7:8n]` only where `cfg_be[n]` is set. It takes effect from the accepting clock edge. Without a write, the stored state and `cfg_rdata` do not change.
- R10: `cfg_rdata` byte lane n returns the stored value of byte (`cfg_addr[7:2]`*4 + n). Bytes that are not implemented read 0x00 and ignore writes.
- R11: At most one of `dram_sel`, `pci_sel` and `wr_blocked` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration request valid |
| cfg_ready | output | 1 | Configuration request accepted (always 1) |
| cfg_we | input | 1 | 1 = write request |
| cfg_addr | input | 8 | Configuration byte address (bits 1:0 ignored) |
| cfg_wdata | input | 32 | Write data, byte lane n for byte address +n |
| cfg_be | input | 4 | Byte enables for write lanes |
| cfg_rdata | output | 32 | Stored bytes of the addressed dword |
| smm_active | input | 1 | Processor is in system management mode |
| mem_addr | input | 20 | Legacy access address |
| mem_write | input | 1 | 1 = access is a write |
| dram_sel | output | 1 | Route access to DRAM |
| pci_sel | output | 1 | Forward access to PCI |
| wr_blocked | output | 1 | Write to a read-only shadow area refused |

## Verification
Random configuration dwords are written with random byte enables and interleaved with random accesses between 0x90000 and 0xFFFFF. Mixing reads and writes against every attribute value separates the read-only case from both the RAM case and the forwarding cases. Directed cases program one segment at a time and probe it together with its even/odd neighbour. A wrong nibble or register choice then shows up as a routing mismatch. The SMRAM window is probed with `smm_active` low and high under each control setting, which tells the mode-qualified enable apart from the unconditional open bit. A zero-enable write and reads of unimplemented bytes show whether stray lanes leak into state.

// File: rtl/lmap_pkg.sv
package lmap_pkg;

  typedef enum logic [1:0] {
    ATTR_FWD0 = 2'd0,
    ATTR_RDONLY = 2'd1,
    ATTR_FWD2 = 2'd2,
    ATTR_RDWR = 2'd3
  } attr_e;

  typedef struct packed {
    logic dram;
    logic pci;
    logic blk;
  } route_t;

  localparam int unsigned CFG_AW = 8;
  localparam int unsigned CFG_LANES = 4;
  localparam int unsigned MEM_AW = 20;
  localparam int unsigned NUM_ATTR_REGS = 7;
  localparam int unsigned NUM_SEGS = 12;
  localparam logic [CFG_AW-1:0] ATTR_BASE = 8'h59;
  localparam logic [CFG_AW-1:0] SMC_ADDR = 8'h72;
  localparam logic [7:0] SMC_RESET = 8'h02;
  localparam int unsigned SMC_QUAL_BIT = 3;
  localparam int unsigned SMC_OPEN_BIT = 6;

endpackage

// File: rtl/lmap_cfg_regs.sv
module lmap_cfg_regs
  import lmap_pkg::*;
#(
  parameter int unsigned AW = CFG_AW,
  parameter int unsigned LANES = CFG_LANES,
  parameter int unsigned NREG = NUM_ATTR_REGS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         addr,
  input  logic [LANES*8-1:0]    wdata,
  input  logic [LANES-1:0]      be,
  output logic [NREG-1:0][7:0]  attr_q,
  output logic [7:0]            smc_q,
  output logic [LANES*8-1:0]    rdata
);
  localparam int unsigned LW = $clog2(LANES);

  logic [AW-LW-1:0] dw_idx;
  assign dw_idx = addr[AW-1:LW];

  for (genvar j = 0; j < NREG; j++) begin : g_attr
    localparam logic [AW-1:0] BA = ATTR_BASE + AW'(j);
    logic hit;
    assign hit = wr_en && (dw_idx == BA[AW-1:LW]) && be[BA[LW-1:0]];
    always_ff @(posedge clk) begin
      if (!rst_n) attr_q[j] <= 8'h00;
      else if (hit) attr_q[j] <= wdata[BA[LW-1:0]*8 +: 8];
    end
  end

  logic smc_hit;
  assign smc_hit = wr_en && (dw_idx == SMC_ADDR[AW-1:LW]) && be[SMC_ADDR[LW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) smc_q <= SMC_RESET;
    else if (smc_hit) smc_q <= wdata[SMC_ADDR[LW-1:0]*8 +: 8];
  end

  always_comb begin
    rdata = '0;
    for (int n = 0; n < LANES; n++) begin
      for (int j = 0; j < NREG; j++) begin
        if ({dw_idx, LW'(n)} == ATTR_BASE + AW'(j)) rdata[n*8 +: 8] = attr_q[j];
      end
      if ({dw_idx, LW'(n)} == SMC_ADDR) rdata[n*8 +: 8] = smc_q;
    end
  end

endmodule

// File: rtl/lmap_seg_lookup.sv
module lmap_seg_lookup
  import lmap_pkg::*;
#(
  parameter int unsigned AW = MEM_AW,
  parameter int unsigned NREG = NUM_ATTR_REGS,
  parameter int unsigned NSEG = NUM_SEGS,
  parameter int unsigned SEG_LOG2 = 14
) (
  input  logic [AW-1:0]         addr,
  input  logic [NREG-1:0][7:0]  attr_q,
  output logic                  in_smram,
  output logic                  in_shadow,
  output attr_e                 attr
);
  localparam int unsigned IW = AW - 2 - SEG_LOG2;

  logic in_top;
  logic [IW-1:0] seg_idx;
  logic [NSEG-1:0][1:0] seg_attr;

  assign in_smram = (addr[AW-1:AW-3] == 3'b101);
  assign in_top = (addr[AW-1:AW-4] == 4'hF);
  assign in_shadow = (addr[AW-1:AW-2] == 2'b11);
  assign seg_idx = addr[AW-3:SEG_LOG2];

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    assign seg_attr[k] = attr_q[1 + k/2][(k%2)*4 +: 2];
  end

  always_comb begin
    attr = ATTR_FWD0;
    if (in_top) begin
      attr = attr_e'(attr_q[0][5:4]);
    end else begin
      for (int k = 0; k < NSEG; k++) begin
        if (seg_idx == IW'(k)) attr = attr_e'(seg_attr[k]);
      end
    end
  end

endmodule

// File: rtl/lmap_route.sv
module lmap_route
  import lmap_pkg::*;
(
  input  logic       in_smram,
  input  logic       in_shadow,
  input  attr_e      attr,
  input  logic       smm_active,
  input  logic [7:0] smc_q,
  input  logic       mem_write,
  output route_t     route
);
  logic smram_open;
  assign smram_open = (smm_active && smc_q[SMC_QUAL_BIT]) || smc_q[SMC_OPEN_BIT];

  always_comb begin
    route = '0;
    if (in_smram) begin
      route.dram = smram_open;
      route.pci = !smram_open;
    end else if (in_shadow) begin
      unique case (attr)
        ATTR_RDWR: route.dram = 1'b1;
        ATTR_RDONLY: begin
          route.dram = !mem_write;
          route.blk = mem_write;
        end
        default: route.pci = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/legacy_map_decoder.sv
module legacy_map_decoder
  import lmap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_valid,
  output logic        cfg_ready,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic [3:0]  cfg_be,
  output logic [31:0] cfg_rdata,
  input  logic        smm_active,
  input  logic [19:0] mem_addr,
  input  logic        mem_write,
  output logic        dram_sel,
  output logic        pci_sel,
  output logic        wr_blocked
);
  logic [NUM_ATTR_REGS-1:0][7:0] attr_q;
  logic [7:0] smc_q;
  logic in_smram, in_shadow;
  attr_e attr;
  route_t route;

  assign cfg_ready = 1'b1;

  lmap_cfg_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_valid && cfg_we),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .be     (cfg_be),
    .attr_q (attr_q),
    .smc_q  (smc_q),
    .rdata  (cfg_rdata)
  );

  lmap_seg_lookup u_seg (
    .addr      (mem_addr),
    .attr_q    (attr_q),
    .in_smram  (in_smram),
    .in_shadow (in_shadow),
    .attr      (attr)
  );

  lmap_route u_route (
    .in_smram   (in_smram),
    .in_shadow  (in_shadow),
    .attr       (attr),
    .smm_active (smm_active),
    .smc_q      (smc_q),
    .mem_write  (mem_write),
    .route      (route)
  );

  assign dram_sel = route.dram;
  assign pci_sel = route.pci;
  assign wr_blocked = route.blk;

endmodule

// File: rtl/lmap_checker.sv
module lmap_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_valid,
  input logic        cfg_we,
  input logic [7:0]  cfg_addr,
  input logic [31:0] cfg_rdata,
  input logic [19:0] mem_addr,
  input logic        mem_write,
  input logic        dram_sel,
  input logic        pci_sel,
  input logic        wr_blocked
);
  p_one_route_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dram_sel, pci_sel, wr_blocked}));

  p_low_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr < 20'hA0000) |-> !(dram_sel || pci_sel || wr_blocked));

  p_block_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |-> mem_write);

  p_smram_routed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr[19:17] == 3'b101) |-> (!wr_blocked && (dram_sel || pci_sel)));

  p_shadow_routed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr[19:18] == 2'b11 && !mem_write) |-> (dram_sel || pci_sel));

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cfg_valid && cfg_we) && $stable(cfg_addr)) |-> $stable(cfg_rdata));
endmodule

bind legacy_map_decoder lmap_checker u_lmap_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_valid  (cfg_valid),
  .cfg_we     (cfg_we),
  .cfg_addr   (cfg_addr),
  .cfg_rdata  (cfg_rdata),
  .mem_addr   (mem_addr),
  .mem_write  (mem_write),
  .dram_sel   (dram_sel),
  .pci_sel    (pci_sel),
  .wr_blocked (wr_blocked)
);

// File: tb/legacy_map_decoder_bench.sv
`timescale 1ns/1ps
module legacy_map_decoder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_valid = 1'b0, cfg_we = 1'b0;
  logic [7:0] cfg_addr = 8'h00;
  logic [31:0] cfg_wdata = '0;
  logic [3:0] cfg_be = '0;
  logic cfg_ready;
  logic [31:0] cfg_rdata;
  logic smm_active = 1'b0;
  logic [19:0] mem_addr = '0;
  logic mem_write = 1'b0;
  logic dram_sel, pci_sel, wr_blocked;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [7:0] ref_cfg [0:255];

  always #5 clk = ~clk;

  legacy_map_decoder u_legacy_map_decoder (.*);

  function automatic bit implemented(input logic [7:0] a);
    return (a >= 8'h59 && a <= 8'h5F) || a == 8'h72;
  endfunction

  function automatic logic [1:0] attr_of(input logic [19:0] a);
    int k;
    logic [7:0] b;
    if (a >= 20'hF0000) return ref_cfg[8'h59][5:4];
    k = int'((a - 20'hC0000) >> 14);
    b = ref_cfg[8'h5A + k / 2];
    return (k % 2 == 1) ? b[5:4] : b[1:0];
  endfunction

  function automatic logic [2:0] exp_route(input logic [19:0] a, input logic wr, input logic smm);
    logic [1:0] at;
    if (a < 20'hA0000) return 3'b000;
    if (a < 20'hC0000)
      return ((smm && ref_cfg[8'h72][3]) || ref_cfg[8'h72][6]) ? 3'b100 : 3'b010;
    at = attr_of(a);
    if (at == 2'd3) return 3'b100;
    if (at == 2'd1) return wr ? 3'b001 : 3'b100;
    return 3'b010;
  endfunction

  function automatic string tag_of(input logic [19:0] a);
    if (a < 20'hA0000) return "R8";
    if (a < 20'hC0000) return "R7";
    case (attr_of(a))
      2'd3: return "R4";
      2'd1: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
    @(negedge clk);
    cfg_valid = 1'b0; cfg_we = 1'b0;
    for (int n = 0; n < 4; n++) begin
      logic [7:0] ba;
      ba = {a[7:2], 2'(n)};
      if (be[n] && implemented(ba)) ref_cfg[ba] = d[n*8 +: 8];
    end
  endtask

  task automatic check_read(input logic [7:0] a, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    cfg_addr = a;
    #1;
    for (int n = 0; n < 4; n++) exp[n*8 +: 8] = ref_cfg[{a[7:2], 2'(n)}];
    n_checks++;
    if (cfg_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s: read 0x%02h got %08h expected %08h", tag, a, cfg_rdata, exp);
    end
  endtask

  task automatic check_route(input logic [19:0] a, input logic wr, input logic smm, input string tag);
    logic [2:0] exp, got;
    @(negedge clk);
    mem_addr = a; mem_write = wr; smm_active = smm;
    #1;
    exp = exp_route(a, wr, smm);
    got = {dram_sel, pci_sel, wr_blocked};
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: addr %05h wr %0b smm %0b got %03b expected %03b", tag, a, wr, smm, got, exp);
    end
    n_checks++;
    if ($countones(got) > 1) begin
      n_fail++;
      $display("FAIL R11: addr %05h got %03b expected at most one", a, got);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    finish_run();
  end

  initial begin
    int unsigned seed;
    logic [7:0] dwsel [0:2];
    seed = 32'd12345;
    void'($urandom(seed));
    dwsel[0] = 8'h58; dwsel[1] = 8'h5C; dwsel[2] = 8'h70;
    for (int i = 0; i < 256; i++) ref_cfg[i] = 8'h00;
    ref_cfg[8'h72] = 8'h02;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check_read(8'h58, "R1");
    check_read(8'h5C, "R1");
    check_read(8'h70, "R1");
    check_route(20'hF8000, 1'b0, 1'b0, "R1");
    check_route(20'hC4000, 1'b1, 1'b0, "R1");

    // R2: top area from byte 0x59 bits 5:4
    cfg_write(8'h58, 32'h0000_3000, 4'b0010);
    check_route(20'hF8000, 1'b1, 1'b0, "R2");
    check_route(20'hFFFFF, 1'b0, 1'b0, "R2");
    check_route(20'hEFFFF, 1'b0, 1'b0, "R2");

    // R3/R5: segment 5 odd nibble of byte 0x5C read-only, segment 4 stays PCI
    cfg_write(8'h5C, 32'h0000_0010, 4'b0001);
    check_route(20'hD4000, 1'b0, 1'b0, "R3");
    check_route(20'hD7FFF, 1'b1, 1'b0, "R5");
    check_route(20'hD0000, 1'b0, 1'b0, "R3");
    // R3/R4: segment 0 even nibble of byte 0x5A
    cfg_write(8'h58, 32'h0003_0000, 4'b0100);
    check_route(20'hC0000, 1'b1, 1'b0, "R4");
    check_route(20'hC4000, 1'b1, 1'b0, "R3");
    // R6: attribute 2
    cfg_write(8'h5C, 32'h2000_0000, 4'b1000);
    check_route(20'hEC000, 1'b1, 1'b0, "R6");

    // R9: zero enables change nothing
    cfg_write(8'h58, 32'hFFFF_FFFF, 4'b0000);
    check_read(8'h58, "R9");
    check_route(20'hC0000, 1'b1, 1'b0, "R9");
    // R10: unimplemented byte ignores writes
    cfg_write(8'h58, 32'h0000_00AA, 4'b0001);
    check_read(8'h58, "R10");

    // R7: SMRAM window
    check_route(20'hA0000, 1'b0, 1'b1, "R7");
    cfg_write(8'h70, 32'h0008_0000, 4'b0100);
    check_route(20'hB0000, 1'b1, 1'b0, "R7");
    check_route(20'hB0000, 1'b1, 1'b1, "R7");
    cfg_write(8'h70, 32'h0040_0000, 4'b0100);
    check_route(20'hBFFFF, 1'b0, 1'b0, "R7");
    check_read(8'h70, "R10");

    // R8: below the window
    check_route(20'h9FFFF, 1'b1, 1'b1, "R8");
    check_route(20'h00000, 1'b0, 1'b0, "R8");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      int unsigned r;
      r = $urandom % 10;
      if (r < 2) begin
        cfg_write(dwsel[$urandom % 3], $urandom, 4'($urandom));
      end else if (r < 3) begin
        check_read(dwsel[$urandom % 3], "R10");
      end else begin
        logic [19:0] a;
        a = 20'h90000 + 20'($urandom % 32'h70000);
        check_route(a, 1'($urandom), 1'($urandom), tag_of(a));
      end
    end

    finish_run();
  end
endmodule